// File: doc/BRIEF.md
# Transmit Address Overlay Unit

This block sits on the transmit side of a chip-to-chip memory link. A local master issues an address into a fixed 256 MB window (top nibble 0x4). The block turns that address into the word carried across the link. It keeps only as many low offset bits as the programmed mask width allows and clears the other offset bits. It then writes a 4-bit privilege index into the top nibble. The index comes from the requester class: core requests get 0xD and every other master gets 0xE. When the overlay is enabled, a programmed constant replaces that index.

The translation path is combinational, so the word follows the address with no clock delay. A small configuration register holds the mask selector, the overlay enable and the overlay value. It loads on a write strobe at the rising clock edge, and translations see the new value from the cycle after that edge. An address outside the window raises a miss flag and drives an all-zero word.

Top module: `tx_addr_overlay`

## Requirements
- R1: After reset, the configuration selects the full 28-bit mask with the overlay disabled. A core request to 0x4567_89A0 therefore yields 0xD567_89A0.
- R2: An address whose bits 31:28 are not 0x4 sets win_miss to 1 and tx_word to 0. An address whose bits 31:28 equal 0x4 sets win_miss to 0.
- R3: For an in-window address, tx_word[27:0] equals loc_addr[27:0] ANDed with (1 << (17+sel)) - 1. So selector 11 keeps 0x0FFF_FFFF, 10 keeps 0x07FF_FFFF, 8 keeps 0x01FF_FFFF and 0 keeps 0x0001_FFFF. Bits 16:0 are always forwarded.
- R4: A selector value above 11 (12 to 15) behaves exactly like 11.
- R5: With the overlay disabled, tx_word[31:28] is 0xD when req_is_core is 1 and 0xE when it is 0.
- R6: With the overlay enabled, tx_word[31:28] equals the programmed overlay value whatever the requester class. Address 0x4567_89A0 with value 5 and selector 11 gives 0x5567_89A0.
- R7: When cfg_we is 1 at a rising edge, cfg_wdata is loaded. Bits 3:0 are the mask selector, bit 4 is the overlay enable and bits 11:8 are the overlay value; bits 7:5 are unused. Translations in the cycle of the write still use the old value, and later translations use the new one.
- R8: When cfg_we is 0, changes on cfg_wdata have no effect on tx_word.
- R9: tx_word and win_miss follow loc_addr and req_is_core within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 12 | Configuration write data: [3:0] selector, [4] overlay enable, [11:8] overlay value |
| loc_addr | input | 32 | Local bus address |
| req_is_core | input | 1 | 1 when the requester is a core, 0 for any other master |
| tx_word | output | 32 | Address word sent across the link |
| win_miss | output | 1 | Address outside the local window |

## Verification
A configuration write and a translation can fall in the same cycle. The bench provokes this by raising cfg_we together with a new address, before the clock edge that loads the register. The output sampled in that cycle must still reflect the old selector and overlay. The vector driven in the next cycle must reflect the new one. Expected words come from a bench model of the configuration that changes only when a write is actually strobed.

// File: rtl/tao_pkg.sv
// Shared types for the transmit address overlay unit.
// Assumes a 4-bit mask selector and a 4-bit privilege index.
package tao_pkg;
    localparam int SEL_W  = 4;
    localparam int PRIV_W = 4;

    typedef struct packed {
        logic [PRIV_W-1:0] ovl_val;
        logic              ovl_en;
        logic [SEL_W-1:0]  mask_sel;
    } tao_cfg_t;
endpackage

// File: rtl/tao_cfg_reg.sv
// Configuration register: loads the selector, overlay enable and value on a strobe.
// Assumes write data packs the selector at [3:0], the enable at [4] and the value at [11:8].
module tao_cfg_reg
    import tao_pkg::*;
#(
    parameter int WD_W    = 12,
    parameter int RST_SEL = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [WD_W-1:0] wdata,
    output tao_cfg_t        cfg
);
    localparam int VAL_LSB = 8;

    // Hold the configuration; reset selects the widest mask with no overlay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.mask_sel <= SEL_W'(RST_SEL);
            cfg.ovl_en   <= 1'b0;
            cfg.ovl_val  <= '0;
        end else if (we) begin
            cfg.mask_sel <= wdata[SEL_W-1:0];
            cfg.ovl_en   <= wdata[SEL_W];
            cfg.ovl_val  <= wdata[VAL_LSB +: PRIV_W];
        end
    end
endmodule

// File: rtl/tao_mask_gen.sv
// Offset mask generator: keeps MIN_BITS + sel low bits, selector clamped to the window width.
// Assumes OFS_W >= MIN_BITS.
module tao_mask_gen #(
    parameter int OFS_W    = 28,
    parameter int MIN_BITS = 17,
    parameter int SEL_W    = 4
) (
    input  logic [SEL_W-1:0] sel,
    output logic [OFS_W-1:0] mask
);
    localparam int MAX_SEL = OFS_W - MIN_BITS;
    localparam int CNT_W   = $clog2(OFS_W + 1) + 1;

    logic [SEL_W-1:0] sel_c;
    logic [CNT_W-1:0] keep;

    // Clamp the selector and turn it into a count of kept bits.
    always_comb begin
        sel_c = (int'(sel) > MAX_SEL) ? SEL_W'(MAX_SEL) : sel;
        keep  = CNT_W'(MIN_BITS) + CNT_W'(sel_c);
    end

    for (genvar i = 0; i < OFS_W; i++) begin : g_bit
        assign mask[i] = (CNT_W'(i) < keep);
    end
endmodule

// File: rtl/tao_priv_sel.sv
// Privilege index selector: requester class code or a programmed override.
// Assumes the class codes are fixed by parameter.
module tao_priv_sel #(
    parameter int          PRIV_W     = 4,
    parameter logic [3:0]  CODE_CORE  = 4'hD,
    parameter logic [3:0]  CODE_OTHER = 4'hE
) (
    input  logic              is_core,
    input  logic              ovl_en,
    input  logic [PRIV_W-1:0] ovl_val,
    output logic [PRIV_W-1:0] priv
);
    // Pick the override when enabled, else the requester class code.
    always_comb begin
        if (ovl_en)       priv = ovl_val;
        else if (is_core) priv = PRIV_W'(CODE_CORE);
        else              priv = PRIV_W'(CODE_OTHER);
    end
endmodule

// File: rtl/tx_addr_overlay.sv
// Transmit address overlay: masks a local-window address and writes the privilege
// index into the top nibble. The path is combinational; only the configuration is registered.
// Assumes the window is selected by the top TAG_W address bits equal to WIN_TAG.
module tx_addr_overlay
    import tao_pkg::*;
#(
    parameter int         ADDR_W   = 32,
    parameter int         TAG_W    = 4,
    parameter logic [3:0] WIN_TAG  = 4'h4,
    parameter int         MIN_BITS = 17,
    parameter int         CFG_WD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_WD_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0]   loc_addr,
    input  logic                req_is_core,
    output logic [ADDR_W-1:0]   tx_word,
    output logic                win_miss
);
    localparam int OFS_W   = ADDR_W - TAG_W;
    localparam int MAX_SEL = OFS_W - MIN_BITS;

    tao_cfg_t          cfg_q;
    logic [OFS_W-1:0]  ofs_mask;
    logic [TAG_W-1:0]  priv_idx;
    logic              win_hit;

    tao_cfg_reg #(.WD_W(CFG_WD_W), .RST_SEL(MAX_SEL)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    tao_mask_gen #(.OFS_W(OFS_W), .MIN_BITS(MIN_BITS), .SEL_W(SEL_W)) u_mask (
        .sel  (cfg_q.mask_sel),
        .mask (ofs_mask)
    );

    tao_priv_sel #(.PRIV_W(TAG_W)) u_priv (
        .is_core (req_is_core),
        .ovl_en  (cfg_q.ovl_en),
        .ovl_val (cfg_q.ovl_val),
        .priv    (priv_idx)
    );

    // Build the outgoing word, or zero it on a window miss.
    always_comb begin
        win_hit  = (loc_addr[ADDR_W-1:OFS_W] == TAG_W'(WIN_TAG));
        win_miss = !win_hit;
        tx_word  = win_hit ? {priv_idx, loc_addr[OFS_W-1:0] & ofs_mask} : '0;
    end
endmodule

// File: rtl/tao_checker.sv
// Property checker for the transmit address overlay unit, attached by bind.
// Assumes the default 32-bit address with a 4-bit tag.
module tao_checker
    import tao_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [11:0] cfg_wdata,
    input logic [31:0] loc_addr,
    input logic        req_is_core,
    input logic [31:0] tx_word,
    input logic        win_miss,
    input tao_cfg_t    cfg
);
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        win_miss |-> tx_word == 32'h0);                                         // R2
    AST_HIT_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_addr[31:28] == 4'h4) |-> !win_miss);                               // R2
    AST_NO_EXTRA_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !win_miss |-> (tx_word[27:0] & ~loc_addr[27:0]) == 28'h0);              // R3
    AST_BASE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !win_miss |-> tx_word[16:0] == loc_addr[16:0]);                         // R3
    AST_CLAMP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_miss && cfg.mask_sel >= 4'd11) |-> tx_word[27:0] == loc_addr[27:0]); // R4
    AST_PRIV_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_miss && !cfg.ovl_en) |-> tx_word[31:28] == (req_is_core ? 4'hD : 4'hE)); // R5
    AST_PRIV_OVL: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_miss && cfg.ovl_en) |-> tx_word[31:28] == cfg.ovl_val);           // R6
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg.mask_sel == $past(cfg_wdata[3:0]));                      // R7
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg));                                              // R8
endmodule

bind tx_addr_overlay tao_checker u_tao_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .loc_addr    (loc_addr),
    .req_is_core (req_is_core),
    .tx_word     (tx_word),
    .win_miss    (win_miss),
    .cfg         (cfg_q)
);

// File: tb/test_tx_addr_overlay.sv
// Scoreboard bench: the driver queues expected words, the monitor compares them mid-cycle.
module test_tx_addr_overlay;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_wdata = '0;
    logic [31:0] loc_addr = '0;
    logic        req_is_core = 1'b0;
    logic [31:0] tx_word;
    logic        win_miss;

    typedef struct {
        logic [31:0] word;
        logic        miss;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // bench model of the configuration
    logic [3:0] m_sel = 4'd11;
    logic       m_en  = 1'b0;
    logic [3:0] m_val = 4'h0;

    always #10 clk = ~clk;   // 50 MHz

    tx_addr_overlay i_tx_addr_overlay (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .loc_addr(loc_addr), .req_is_core(req_is_core),
        .tx_word(tx_word), .win_miss(win_miss)
    );

    function automatic exp_t model(input logic [31:0] a, input logic core, input string tag);
        exp_t e;
        int   s;
        logic [31:0] mask;
        logic [3:0]  p;
        e.tag = tag;
        if (a[31:28] != 4'h4) begin
            e.word = 32'h0;
            e.miss = 1'b1;
        end else begin
            s    = (m_sel > 4'd11) ? 11 : int'(m_sel);
            mask = (32'h1 << (17 + s)) - 32'h1;
            p    = m_en ? m_val : (core ? 4'hD : 4'hE);
            e.word = {p, a[27:0] & mask[27:0]};
            e.miss = 1'b0;
        end
        return e;
    endfunction

    task automatic drive(input logic [31:0] a, input logic core, input logic we,
                         input logic [11:0] wd, input string tag);
        @(negedge clk);
        loc_addr    = a;
        req_is_core = core;
        cfg_we      = we;
        cfg_wdata   = wd;
        q.push_back(model(a, core, tag));
        if (we && rst_n) begin
            m_sel = wd[3:0];
            m_en  = wd[4];
            m_val = wd[11:8];
        end
    endtask

    task automatic vec(input logic [31:0] a, input logic core, input string tag);
        drive(a, core, 1'b0, cfg_wdata, tag);
    endtask

    task automatic wr(input logic [11:0] wd, input string tag);
        drive(32'h4567_89A0, 1'b1, 1'b1, wd, tag);
    endtask

    // monitor: a quarter period after each drive point
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (tx_word !== e.word || win_miss !== e.miss) begin
                    n_fail++;
                    $display("FAIL %s: word=%h miss=%b expected word=%h miss=%b",
                             e.tag, tx_word, win_miss, e.word, e.miss);
                end
            end
        end
    end

    // watchdog
    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        vec(32'h4567_89A0, 1'b1, "R1 reset state core");        // checked while reset held
        @(negedge clk);
        rst_n = 1'b1;
        vec(32'h4567_89A0, 1'b1, "R1 after reset core");
        vec(32'h4567_89A0, 1'b0, "R5 other master");
        vec(32'h4ABC_DEF1, 1'b1, "R5 core");
        vec(32'h3FFF_FFFF, 1'b1, "R2 below window");
        vec(32'h5000_0000, 1'b0, "R2 above window");
        vec(32'h0000_0000, 1'b1, "R2 zero address");
        vec(32'h4FFF_FFFF, 1'b1, "R9 top of window same cycle");
        vec(32'h4000_0000, 1'b0, "R9 base of window same cycle");

        wr(12'h00A, "R7 write sel 10, old value in write cycle");
        vec(32'h4FFF_FFFF, 1'b1, "R3 sel 10");
        wr(12'h008, "R7 write sel 8");
        vec(32'h4FFF_FFFF, 1'b1, "R3 sel 8");
        wr(12'h000, "R7 write sel 0");
        vec(32'h4FFF_FFFF, 1'b0, "R3 sel 0");
        vec(32'h4567_89A0, 1'b1, "R3 sel 0 pattern");
        wr(12'h0EF, "R7 write sel 15 unused bits set");
        vec(32'h4FFF_FFFF, 1'b1, "R4 sel 15 clamps");
        wr(12'h00C, "R7 write sel 12");
        vec(32'h4ABC_DEF1, 1'b0, "R4 sel 12 clamps");

        wr(12'h51B, "R7 write overlay 5 sel 11");
        vec(32'h4567_89A0, 1'b0, "R6 overlay other");
        vec(32'h4567_89A0, 1'b1, "R6 overlay core");
        vec(32'h7567_89A0, 1'b1, "R2 miss with overlay");

        // cfg_wdata changes without strobe
        drive(32'h4567_89A0, 1'b1, 1'b0, 12'h000, "R8 wdata change ignored");
        drive(32'h4FFF_FFFF, 1'b0, 1'b0, 12'hF08, "R8 wdata change ignored");
        vec(32'h4123_4567, 1'b1, "R8 config held");

        wr(12'h00B, "R7 write overlay off");
        vec(32'h4567_89A0, 1'b1, "R5 core after overlay off");
        vec(32'h4567_89A0, 1'b0, "R5 other after overlay off");

        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule